// File: doc/BRIEF.md
# Serial Peripheral Target with Automatic Clock Polarity

This block is the target side of a four-wire serial peripheral link. It moves one byte in each direction per word and may carry several words under one select. The block never learns the clock polarity from a setting. Each time the select line goes active, it reads the level of the serial clock. A low clock means an idle-low transfer (mode 0). A high clock means an idle-high transfer (mode 3). In both cases incoming data is captured on rising serial-clock edges and outgoing data moves on falling edges.

All three serial inputs are brought into a faster system clock through flip-flop synchronisers. Edges are found in that domain. On the host side, the block offers a one-cycle strobe with each received byte. It also has a load interface that shows when the byte on `tx_data_i` has been captured for sending. The serial output is released to high impedance while the target is not selected, and an output-enable pin is provided for the pad.

Top module: `spi_autopol_target`

## Requirements
- R1: During and right after reset, `miso_oe_o`, `rx_valid_o` and `tx_take_o` are 0 and `rx_data_o` is all zeros.
- R2: The idle level of `sclk_i` when `cs_n_i` falls is latched as the polarity for that selection: low selects mode 0, high selects mode 3. Both modes deliver the same received and sent bytes.
- R3: `mosi_i` is sampled on rising `sclk_i` edges, most significant bit first. After the eighth rising edge of a word, `rx_valid_o` is high for exactly one system cycle with the assembled byte on `rx_data_o`.
- R4: When select is asserted, `tx_data_i` is captured, `tx_take_o` pulses for one cycle, and its bit 7 appears on `miso_o` with `miso_oe_o` high before the first serial-clock edge. Later bits advance on falling `sclk_i` edges.
- R5: In mode 3, the first falling `sclk_i` edge after select does not advance `miso_o`.
- R6: Within one selection, the first falling edge after a completed word captures a new `tx_data_i` byte with a `tx_take_o` pulse. A mode-0 selection of N words therefore gives N+1 pulses, and a mode-3 selection gives N.
- R7: While `cs_n_i` is high, `miso_oe_o` is 0 and `miso_o` is high impedance.
- R8: If `cs_n_i` rises before a word completes, the partial byte is discarded with no `rx_valid_o`, and the next selection starts a fresh word.
- R9: `rx_data_o` changes only in a cycle where `rx_valid_o` is high and otherwise keeps its last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the controller |
| cs_n_i | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data into the target |
| miso_o | output | 1 | Serial data out, high impedance when not selected |
| miso_oe_o | output | 1 | Driver enable for `miso_o` |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_data_o | output | WIDTH | Last received byte |
| tx_data_i | input | WIDTH | Byte to send next |
| tx_take_o | output | 1 | `tx_data_i` captured this cycle |

## Verification
The checks assume that the controller never moves `sclk_i` while it changes `cs_n_i`. They also assume that each serial-clock phase lasts long enough for the synchroniser and edge detector to see it, and that select is held high for several system cycles between selections. The stimulus settles the clock at its idle level four cycles before select. It waits six cycles after select before the first edge, and it keeps every serial-clock phase five system cycles long. MOSI changes only while the clock is low. Random selections vary the mode, the word count and the data, and directed runs cover a mid-word abort and back-to-back words.

// File: rtl/spi_autopol_pkg.sv
package spi_autopol_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // not selected, output released
    ST_LEAD  = 2'd1,  // idle-high selection, waiting for the clock to leave idle
    ST_SHIFT = 2'd2   // shifting words
  } tgt_state_e;
endpackage

// File: rtl/spi_autopol_sync.sv
module spi_autopol_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_autopol_edge.sv
module spi_autopol_edge #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/spi_autopol_core.sv
module spi_autopol_core
  import spi_autopol_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_on_i,
  input  logic             sel_off_i,
  input  logic             sclk_lvl_i,
  input  logic             sclk_rise_i,
  input  logic             sclk_fall_i,
  input  logic             mosi_i,
  input  logic [WIDTH-1:0] tx_data_i,
  output logic             drive_o,
  output logic             miso_bit_o,
  output logic             rx_valid_o,
  output logic [WIDTH-1:0] rx_data_o,
  output logic             tx_take_o
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(WIDTH - 1);

  tgt_state_e       state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [WIDTH-1:0] rx_sh_q, rx_sh_d;
  logic [WIDTH-1:0] tx_sh_q, tx_sh_d;
  logic [WIDTH-1:0] rx_data_q, rx_data_d;
  logic             rx_valid_q, rx_valid_d;
  logic             take;
  logic [WIDTH-1:0] rx_next;

  assign rx_next = {rx_sh_q[WIDTH-2:0], mosi_i};

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    rx_sh_d    = rx_sh_q;
    tx_sh_d    = tx_sh_q;
    rx_data_d  = rx_data_q;
    rx_valid_d = 1'b0;
    take       = 1'b0;
    if (sel_on_i) begin
      // the clock level at select is the idle level of this transfer
      state_d = sclk_lvl_i ? ST_LEAD : ST_SHIFT;
      cnt_d   = '0;
      tx_sh_d = tx_data_i;
      take    = 1'b1;
    end else if (sel_off_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (state_q != ST_IDLE) begin
      if (sclk_rise_i) begin
        rx_sh_d = rx_next;
        if (cnt_q == LAST_BIT) begin
          cnt_d      = '0;
          rx_valid_d = 1'b1;
          rx_data_d  = rx_next;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (sclk_fall_i) begin
        if (state_q == ST_LEAD) begin
          state_d = ST_SHIFT;  // clock leaving idle-high: not a shift edge
        end else if (cnt_q == '0) begin
          tx_sh_d = tx_data_i;  // word boundary: fetch next byte
          take    = 1'b1;
        end else begin
          tx_sh_d = {tx_sh_q[WIDTH-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      rx_sh_q    <= rx_sh_d;
      tx_sh_q    <= tx_sh_d;
      rx_data_q  <= rx_data_d;
      rx_valid_q <= rx_valid_d;
    end
  end

  assign drive_o    = (state_q != ST_IDLE);
  assign miso_bit_o = tx_sh_q[WIDTH-1];
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
  assign tx_take_o  = take;
endmodule

// File: rtl/spi_autopol_target.sv
module spi_autopol_target #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             cs_n_i,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  output logic             rx_valid_o,
  output logic [WIDTH-1:0] rx_data_o,
  input  logic [WIDTH-1:0] tx_data_i,
  output logic             tx_take_o
);
  logic sclk_s, cs_n_s, mosi_s;
  logic sclk_rise, sclk_fall, cs_rise, cs_fall;
  logic drive, miso_bit;

  spi_autopol_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .async_i(sclk_i), .level_o(sclk_s));
  spi_autopol_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .async_i(cs_n_i), .level_o(cs_n_s));
  spi_autopol_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .async_i(mosi_i), .level_o(mosi_s));

  spi_autopol_edge #(.RST_VAL(1'b0)) u_edge_sclk (
    .clk(clk), .rst_n(rst_n), .level_i(sclk_s), .rise_o(sclk_rise), .fall_o(sclk_fall));
  spi_autopol_edge #(.RST_VAL(1'b1)) u_edge_cs (
    .clk(clk), .rst_n(rst_n), .level_i(cs_n_s), .rise_o(cs_rise), .fall_o(cs_fall));

  spi_autopol_core #(.WIDTH(WIDTH)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_on_i   (cs_fall),
    .sel_off_i  (cs_rise),
    .sclk_lvl_i (sclk_s),
    .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall),
    .mosi_i     (mosi_s),
    .tx_data_i  (tx_data_i),
    .drive_o    (drive),
    .miso_bit_o (miso_bit),
    .rx_valid_o (rx_valid_o),
    .rx_data_o  (rx_data_o),
    .tx_take_o  (tx_take_o)
  );

  assign miso_oe_o = drive;
  assign miso_o    = drive ? miso_bit : 1'bz;
endmodule

// File: rtl/spi_autopol_chk.sv
module spi_autopol_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n_i,
  input logic             miso_oe_o,
  input logic             rx_valid_o,
  input logic [WIDTH-1:0] rx_data_o,
  input logic             tx_take_o
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!miso_oe_o && !rx_valid_o && !tx_take_o);
    end
  end

  // R3
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_o |-> $stable(rx_data_o));

  // R7
  deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !miso_oe_o);

  // R4
  take_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take_o |=> miso_oe_o);
endmodule

bind spi_autopol_target spi_autopol_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n_i    (cs_n_i),
  .miso_oe_o (miso_oe_o),
  .rx_valid_o(rx_valid_o),
  .rx_data_o (rx_data_o),
  .tx_take_o (tx_take_o)
);

// File: tb/spi_autopol_target_tb.sv
module spi_autopol_target_tb;
  localparam int W = 8;
  localparam int H = 5;  // system cycles per serial-clock phase

  logic clk = 1'b0;
  logic rst_n;
  logic sclk, cs_n, mosi;
  logic [W-1:0] tx_data;
  wire  miso;
  logic miso_oe, rx_valid, tx_take;
  logic [W-1:0] rx_data;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] txq [8];
  logic [W-1:0] mosiq [8];
  logic [W-1:0] rx_log [8];
  int take_cnt = 0;
  int take_base = 0;
  int rx_cnt = 0;

  always #5 clk = ~clk;

  spi_autopol_target #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .tx_data_i(tx_data), .tx_take_o(tx_take));

  assign tx_data = txq[(take_cnt - take_base) % 8];

  always @(posedge clk) begin
    if (tx_take) take_cnt <= take_cnt + 1;
    if (rx_valid) begin
      rx_log[rx_cnt % 8] <= rx_data;
      rx_cnt <= rx_cnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_takes(input bit idle_high, input int nwords);
    return idle_high ? nwords : nwords + 1;
  endfunction

  // one selection; abort_bits > 0 ends it after that many bits
  task automatic select_run(input bit idle_high, input int nwords, input int abort_bits);
    logic [W-1:0] got [8];
    int rx0;
    int nbits;
    string mreq;
    mreq = idle_high ? "R5" : "R2";
    @(negedge clk);
    sclk = idle_high;
    repeat (4) @(negedge clk);
    take_base = take_cnt;
    rx0 = rx_cnt;
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4", "oe after select", int'(miso_oe), 1);
    chk("R4", "first miso bit", int'(miso), int'(txq[0][W-1]));
    nbits = (abort_bits > 0) ? abort_bits : nwords * W;
    for (int i = 0; i < nbits; i++) begin
      if (idle_high) sclk = 1'b0;
      mosi = mosiq[i / W][W - 1 - (i % W)];
      repeat (H) @(negedge clk);
      got[i / W][W - 1 - (i % W)] = miso;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      if (!idle_high) sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7", "oe after deselect", int'(miso_oe), 0);
    if (abort_bits > 0) begin
      chk("R8", "no strobe on abort", rx_cnt - rx0, 0);
    end else begin
      chk("R3", "strobe count", rx_cnt - rx0, nwords);
      for (int b = 0; b < nwords; b++) begin
        chk(idle_high ? "R2" : "R3", "received byte", int'(rx_log[(rx0 + b) % 8]), int'(mosiq[b]));
        chk(b > 0 ? "R6" : mreq, "sent byte", int'(got[b]), int'(txq[b]));
      end
      chk("R6", "load pulses", take_cnt - take_base, exp_takes(idle_high, nwords));
      chk("R9", "data held", int'(rx_data), int'(mosiq[nwords - 1]));
    end
  endtask

  task automatic fill_random(input int nwords);
    for (int b = 0; b < 8; b++) begin
      txq[b]   = W'($urandom);
      mosiq[b] = W'($urandom);
    end
    if (nwords < 0) txq[0] = '0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    for (int b = 0; b < 8; b++) begin txq[b] = '0; mosiq[b] = '0; end
    repeat (4) @(negedge clk);
    chk("R1", "oe in reset", int'(miso_oe), 0);
    chk("R1", "valid in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "data after reset", int'(rx_data), 0);
    chk("R1", "take after reset", int'(tx_take), 0);
    chk("R7", "oe idle", int'(miso_oe), 0);

    // directed: mode 0 single word
    txq[0] = 8'h3C; mosiq[0] = 8'hA5; txq[1] = 8'h00;
    select_run(1'b0, 1, 0);
    // directed: mode 3 single word, distinct MSB pattern
    txq[0] = 8'h81; mosiq[0] = 8'h7E;
    select_run(1'b1, 1, 0);
    // directed: mode 3 three words back to back
    txq[0] = 8'hC3; txq[1] = 8'h5A; txq[2] = 8'h0F;
    mosiq[0] = 8'h12; mosiq[1] = 8'hF0; mosiq[2] = 8'h99;
    select_run(1'b1, 3, 0);
    // directed: mode 0 two words
    txq[0] = 8'hFF; txq[1] = 8'h01; mosiq[0] = 8'h00; mosiq[1] = 8'hFE;
    select_run(1'b0, 2, 0);
    // directed: abort mid-word, then a clean word
    mosiq[0] = 8'hE0;
    select_run(1'b1, 1, 3);
    txq[0] = 8'h96; mosiq[0] = 8'h69;
    select_run(1'b0, 1, 0);
    chk("R8", "word after abort", int'(rx_data), 8'h69);

    // random selections
    for (int r = 0; r < 14; r++) begin
      fill_random(1);
      select_run(1'($urandom), 1 + int'($urandom % 4), 0);
    end

    finish_run();
  end
endmodule